// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block is a management master for the two-wire PHY management bus. It runs IEEE 802.3 Clause 22 read and write frames. Software sees two 32-bit registers. A command register holds a start bit, a frame-type bit, the opcode, the PHY and register addresses and the write data. A status/configuration register holds the MDC half-period, the sampling-edge choice, the capture delay, an idle flag and the last word read from the PHY.

A write to the command register with the start bit set, the Clause 22 type and a valid opcode launches one frame. The block then does the following:

- It runs MDC from its divider.
- It shifts the preamble, start code, opcode and addresses out on the data line.
- For a write, it drives the turnaround and data.
- For a read, it releases the line and captures sixteen bits.

When the frame ends, the start bit clears itself and the idle flag returns. The pad is not part of the block. It appears as separate output, output-enable and input pins.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset the command register reads 0, the status register reads 0x0A010000 (threshold 10, rising-edge sampling, zero delay, idle flag bit 16 set, read data 0), and MDC, output-enable are low.
- R2: A write to byte offset 0 with bit 31 set, bit 28 set and opcode bits 27:26 equal to 01 (write) or 10 (read) starts a frame. Bit 31 of offset 0 then reads 1 and the idle flag reads 0. At the end, bit 31 reads 0 and the command fields (bits 28:0) keep the accepted values.
- R3: MDC stays low while idle. Each half-period lasts the threshold (status bits 31:24) system clocks, and a threshold of 0 counts as 1. A write frame keeps the block busy for exactly 128*half+1 clocks from the accepting edge, across 64 MDC periods.
- R4: Each frame sends 32 ones, then 01, then the opcode, then the 5-bit PHY address (bits 25:21) and the 5-bit register address (bits 20:16), all MSB first. A new bit is launched only when MDC falls.
- R5: A write frame drives turnaround 1,0 and then the 16 data bits of bits 15:0, MSB first, with output-enable high for all 64 bits.
- R6: A read frame drops output-enable for the turnaround and data bits (bit positions 46 to 63 of the frame). It captures 16 bits MSB first into status bits 15:0.
- R7: Status bit 23 selects the capture edge (0 rising, 1 falling MDC). Status bits 22:20 delay each capture by that many system clocks after the chosen edge.
- R8: A command with bit 28 clear, or with opcode 00 or 11, is ignored. There is no busy, no MDC and no change to the command readback.
- R9: Writes to either register while a frame runs are ignored. Neither the frame nor the register contents change.
- R10: Output-enable is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset: 0 command, 4 status/configuration |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench acts as a PHY. It counts MDC falls to know the bit position and drives read data on the low phase. It keeps its own queue of capture instants, so it can predict the read word for every edge and delay setting. That includes delays long enough that a late capture picks up the following bit: a design that ignored the delay, or sampled on the wrong edge, returns a different word.

Frames are decoded bit by bit against the command. A design that launched data on the rising edge, or kept driving during a read turnaround, shows up there. Exact busy lengths at thresholds 10 and 0 catch off-by-one errors in the divider and the zero-threshold case. Mid-frame writes and rejected frame types check that no state leaks through while busy or idle.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;

   localparam int CMD_OFS  = 0;
   localparam int CFG_OFS  = 4;

   localparam int GO_BIT   = 31;
   localparam int TYPE_BIT = 28;
   localparam int THR_W    = 8;
   localparam int LAT_W    = 3;
   localparam int WORD_W   = 16;
   localparam int ADR_W    = 5;

   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;

   typedef struct packed {
      logic              c22;
      logic [1:0]        opc;
      logic [ADR_W-1:0]  phy;
      logic [ADR_W-1:0]  regad;
      logic [WORD_W-1:0] wdata;
   } cmd_t;

   typedef struct packed {
      logic [THR_W-1:0] thr;
      logic             edge_fall;
      logic [LAT_W-1:0] lat;
   } cfg_t;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_SHIFT,
      SEQ_DRAIN
   } seq_state_t;

endpackage

// File: rtl/mdio_c22_regs.sv
module mdio_c22_regs
   import mdio_c22_pkg::*;
#(
   parameter int               ADDR_W   = 4,
   parameter logic [THR_W-1:0] DEF_THR  = 8'd10,
   parameter logic             DEF_EDGE = 1'b0,
   parameter logic [LAT_W-1:0] DEF_LAT  = 3'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic [WORD_W-1:0] rx_word,
   output cmd_t              cmd_in,
   output cmd_t              cmd_q,
   output cfg_t              cfg_q,
   output logic              start
);

   logic sel_cmd, sel_cfg, opc_ok;
   logic unused_bits;

   assign sel_cmd = (bus_addr == ADDR_W'(CMD_OFS));
   assign sel_cfg = (bus_addr == ADDR_W'(CFG_OFS));
   assign cmd_in  = cmd_t'(bus_wdata[28:0]);
   assign opc_ok  = (cmd_in.opc == OPC_WRITE) || (cmd_in.opc == OPC_READ);
   assign start   = bus_wr && sel_cmd && !busy && bus_wdata[GO_BIT]
                    && bus_wdata[TYPE_BIT] && opc_ok;
   assign unused_bits = ^bus_wdata[30:29];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (start) begin
         cmd_q <= cmd_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{thr: DEF_THR, edge_fall: DEF_EDGE, lat: DEF_LAT};
      end else if (bus_wr && sel_cfg && !busy) begin
         cfg_q <= '{thr: bus_wdata[31:24], edge_fall: bus_wdata[23],
                    lat: bus_wdata[22:20]};
      end
   end

   always_comb begin
      if (sel_cmd) begin
         bus_rdata = {busy, 2'b00, cmd_q};
      end else if (sel_cfg) begin
         bus_rdata = {cfg_q.thr, cfg_q.edge_fall, cfg_q.lat, 3'b000, !busy, rx_word};
      end else begin
         bus_rdata = '0;
      end
   end

endmodule

// File: rtl/mdio_c22_mdc_gen.sv
module mdio_c22_mdc_gen #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [THR_W-1:0] thr,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);

   logic [THR_W-1:0] cnt;
   logic [THR_W-1:0] half;
   logic             tick;

   assign half     = (thr == '0) ? THR_W'(1) : thr;
   assign tick     = (cnt == half - THR_W'(1));
   assign rise_stb = run && tick && !mdc;
   assign fall_stb = run && tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= !mdc;
      end else begin
         cnt <= cnt + THR_W'(1);
      end
   end

endmodule

// File: rtl/mdio_c22_sampler.sv
module mdio_c22_sampler #(
   parameter int LAT_W  = 3,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [LAT_W-1:0]  lat,
   input  logic              mdio_i,
   output logic              pend,
   output logic [WORD_W-1:0] rx_word
);

   localparam int NST = 1 << LAT_W;

   logic [NST-1:0] dly;
   logic [NST-1:0] wait_bits;
   logic           take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly <= '0;
      end else begin
         dly <= {dly[NST-2:0], evt};
      end
   end

   assign take = (lat == '0) ? evt : dly[lat - LAT_W'(1)];

   for (genvar k = 0; k < NST; k++) begin : g_wait
      assign wait_bits[k] = dly[k] && ({1'b0, lat} > (LAT_W+1)'(k + 1));
   end

   assign pend = |wait_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word <= '0;
      end else if (take) begin
         rx_word <= {rx_word[WORD_W-2:0], mdio_i};
      end
   end

endmodule

// File: rtl/mdio_c22_seq.sv
module mdio_c22_seq
   import mdio_c22_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int IDX_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cmd_t              cmd_in,
   input  logic              edge_fall,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              pend,
   output logic              busy,
   output logic              run,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              evt,
   output logic              rd_active,
   output logic [IDX_W-1:0]  bitidx
);

   localparam int FRAME   = PRE_LEN + 32;
   localparam int LAST    = FRAME - 1;
   localparam int TA_IDX  = PRE_LEN + 14;
   localparam int DAT_IDX = PRE_LEN + 16;

   seq_state_t       state;
   logic [FRAME-1:0] sr;
   logic [FRAME-1:0] load_vec;
   logic             is_rd, new_rd, in_data, released;
   logic             unused_type;

   assign new_rd      = (cmd_in.opc == OPC_READ);
   assign unused_type = cmd_in.c22;
   assign load_vec    = {{PRE_LEN{1'b1}}, 2'b01, cmd_in.opc, cmd_in.phy, cmd_in.regad,
                         (new_rd ? 2'b11 : 2'b10),
                         (new_rd ? {WORD_W{1'b1}} : cmd_in.wdata)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         sr     <= '1;
         bitidx <= '0;
         is_rd  <= 1'b0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state  <= SEQ_SHIFT;
                  sr     <= load_vec;
                  bitidx <= '0;
                  is_rd  <= new_rd;
               end
            end
            SEQ_SHIFT: begin
               if (fall_stb) begin
                  if (bitidx == IDX_W'(LAST)) begin
                     state <= SEQ_DRAIN;
                  end else begin
                     sr     <= {sr[FRAME-2:0], 1'b1};
                     bitidx <= bitidx + IDX_W'(1);
                  end
               end
            end
            SEQ_DRAIN: begin
               if (!pend) begin
                  state <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state != SEQ_IDLE);
   assign run       = (state == SEQ_SHIFT);
   assign released  = is_rd && (bitidx >= IDX_W'(TA_IDX));
   assign in_data   = (bitidx >= IDX_W'(DAT_IDX));
   assign mdio_o    = run ? sr[FRAME-1] : 1'b1;
   assign mdio_oe   = run && !released;
   assign evt       = run && is_rd && in_data && (edge_fall ? fall_stb : rise_stb);
   assign rd_active = is_rd;

endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
   import mdio_c22_pkg::*;
#(
   parameter int               ADDR_W   = 4,
   parameter int               PRE_LEN  = 32,
   parameter logic [THR_W-1:0] DEF_THR  = 8'd10,
   parameter logic             DEF_EDGE = 1'b0,
   parameter logic [LAT_W-1:0] DEF_LAT  = 3'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   localparam int FRAME_BITS = PRE_LEN + 32;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach byte offset 4");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if (DEF_THR == '0) begin : g_bad_thr
      $error("DEF_THR must be nonzero");
   end

   cmd_t              cmd_in, cmd_q;
   cfg_t              cfg_q;
   logic              start, busy, run, rise_stb, fall_stb, evt, pend, seq_rd;
   logic [WORD_W-1:0] rx_word;
   logic [IDX_W-1:0]  seq_bitidx;

   mdio_c22_regs #(
      .ADDR_W(ADDR_W), .DEF_THR(DEF_THR), .DEF_EDGE(DEF_EDGE), .DEF_LAT(DEF_LAT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .rx_word(rx_word),
      .cmd_in(cmd_in), .cmd_q(cmd_q), .cfg_q(cfg_q), .start(start)
   );

   mdio_c22_mdc_gen #(.THR_W(THR_W)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(run), .thr(cfg_q.thr),
      .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_c22_seq #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in),
      .edge_fall(cfg_q.edge_fall), .rise_stb(rise_stb), .fall_stb(fall_stb),
      .pend(pend), .busy(busy), .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .evt(evt), .rd_active(seq_rd), .bitidx(seq_bitidx)
   );

   mdio_c22_sampler #(.LAT_W(LAT_W), .WORD_W(WORD_W)) u_samp (
      .clk(clk), .rst_n(rst_n), .evt(evt), .lat(cfg_q.lat), .mdio_i(mdio_i),
      .pend(pend), .rx_word(rx_word)
   );

endmodule

// File: rtl/mdio_c22_checker.sv
module mdio_c22_checker #(
   parameter int ADDR_W  = 4,
   parameter int IDX_W   = 6,
   parameter int TA_IDX  = 46
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [28:0]       cmd_bits,
   input logic [11:0]       cfg_bits,
   input logic              rd_active,
   input logic [IDX_W-1:0]  bitidx
);

   p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));

   p_launch_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

   p_frozen_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cmd_bits) && $stable(cfg_bits)));

   p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_active && (bitidx >= IDX_W'(TA_IDX))) |-> !mdio_oe);

   p_reject_c45_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_wr && (bus_addr == '0) && !bus_wdata[28]) |=> !busy);

   p_mdc_low_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !mdc);

endmodule

bind mdio_c22_master mdio_c22_checker #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TA_IDX(PRE_LEN + 14)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .cmd_bits(cmd_q), .cfg_bits(cfg_q), .rd_active(seq_rd), .bitidx(seq_bitidx)
);

// File: tb/mdio_c22_master_bench.sv
module mdio_c22_master_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = 4'd4;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_c22_master u_mdio_c22_master (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int checks = 0;
   int fails  = 0;

   // PHY-side reference model state
   int          n_idx = 0;
   int          falls = 0;
   logic        prev_mdc = 1'b0;
   int          tq[$];
   logic [15:0] cap_word = '0;
   int          cap_cnt = 0;
   logic        m_rd = 1'b0;
   logic        m_edge = 1'b0;
   int          m_lat = 0;
   logic [15:0] m_phy = '0;
   logic        obit[64];
   logic        ooe[64];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic take_due(input int t);
      while (tq.size() > 0 && tq[0] == t) begin
         cap_word = {cap_word[14:0], mdio_i};
         cap_cnt++;
         void'(tq.pop_front());
      end
   endtask

   always @(negedge clk) begin
      #2;
      n_idx++;
      if (rst_n && bus_addr == 4'd4 && bus_rdata[16]) begin
         chk("R10", "idle pins {mdc,oe}", {30'd0, mdc, mdio_oe}, 32'd0);
      end
      if (!prev_mdc && mdc) begin
         if (falls < 64) begin
            obit[falls] = mdio_o;
            ooe[falls]  = mdio_oe;
         end
         if (m_rd && !m_edge && falls >= 48 && falls <= 63) tq.push_back(n_idx + m_lat - 1);
      end
      if (prev_mdc && !mdc) begin
         if (m_rd && m_edge && falls >= 48 && falls <= 63) tq.push_back(n_idx + m_lat - 1);
         falls++;
      end
      prev_mdc = mdc;
      take_due(n_idx - 1);
      mdio_i = (falls >= 48 && falls <= 63) ? m_phy[63 - falls] : 1'b1;
      take_due(n_idx);
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_addr  = 4'd4;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
      bus_addr = 4'd4;
   endtask

   task automatic do_frame(input string req, input logic is_rd, input logic [4:0] phy,
                           input logic [4:0] regad, input logic [15:0] wd,
                           input logic [15:0] phyval, input int half, input logic edge_sel,
                           input int lat, input bit time_chk, input bit poke);
      logic [31:0] v, cmdw, cfg_before;
      logic [45:0] hdr;
      logic [17:0] pay;
      int cnt, herr, perr;
      rd(4'd4, cfg_before);
      falls = 0; cap_word = '0; cap_cnt = 0; tq.delete();
      m_rd = is_rd; m_edge = edge_sel; m_lat = lat; m_phy = phyval;
      for (int i = 0; i < 64; i++) begin obit[i] = 1'bx; ooe[i] = 1'bx; end
      cmdw = {1'b1, 2'b00, 1'b1, (is_rd ? 2'b10 : 2'b01), phy, regad, wd};
      wr(4'd0, cmdw);
      rd(4'd0, v);
      chk("R2", "start bit while running", {31'd0, v[31]}, 32'd1);
      rd(4'd4, v);
      chk("R2", "idle flag while running", {31'd0, v[16]}, 32'd0);
      if (poke) begin
         repeat (10) @(negedge clk);
         wr(4'd0, {1'b1, 2'b00, 1'b1, 2'b10, 5'h1F, 5'h1F, 16'h0000});
         wr(4'd4, {8'd9, 1'b1, 3'd6, 20'h0});
      end
      cnt = 0;
      rd(4'd4, v);
      while (v[16] == 1'b0) begin
         cnt++;
         @(negedge clk);
         rd(4'd4, v);
      end
      if (time_chk) chk("R3", "busy clocks of write frame", cnt, 128 * half + 1);
      @(negedge clk);
      chk("R3", "MDC periods in frame", falls, 64);
      rd(4'd0, v);
      chk(poke ? "R9" : "R2", "command readback after frame", v, {1'b0, cmdw[30:0]});
      hdr = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, regad};
      pay = {2'b10, wd};
      herr = 0; perr = 0;
      for (int i = 0; i < 46; i++) begin
         if (obit[i] !== hdr[45 - i] || ooe[i] !== 1'b1) herr++;
      end
      for (int i = 46; i < 64; i++) begin
         if (is_rd) begin
            if (ooe[i] !== 1'b0) perr++;
         end else if (obit[i] !== pay[63 - i] || ooe[i] !== 1'b1) perr++;
      end
      chk("R4", "header bit errors", herr, 0);
      chk(is_rd ? "R6" : "R5", "payload bit errors", perr, 0);
      if (is_rd) begin
         rd(4'd4, v);
         chk("R6", "captured bit count", cap_cnt, 16);
         chk(req, "read word", {16'd0, v[15:0]}, {16'd0, cap_word});
      end
      if (poke) begin
         rd(4'd4, v);
         chk("R9", "config after busy write", {v[31:20], 20'd0}, {cfg_before[31:20], 20'd0});
      end
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(4'd0, v);
      chk("R1", "command reg after reset", v, 32'h0);
      rd(4'd4, v);
      chk("R1", "status reg after reset", v, 32'h0A01_0000);
      chk("R1", "mdc/oe after reset", {30'd0, mdc, mdio_oe}, 32'd0);

      // write frame at the default half-period of 10
      do_frame("R5", 1'b0, 5'h11, 5'h0A, 16'hA53C, 16'h0, 10, 1'b0, 0, 1'b1, 1'b0);

      wr(4'd4, {8'd3, 1'b0, 3'd0, 20'h0});
      rd(4'd4, v);
      chk("R3", "threshold readback", {24'd0, v[31:24]}, 32'd3);

      // R6: rising-edge sampling without delay returns the PHY word as driven
      do_frame("R6", 1'b1, 5'h03, 5'h01, 16'h0, 16'h8001, 3, 1'b0, 0, 1'b0, 1'b0);
      rd(4'd4, v);
      chk("R6", "read word literal", {16'd0, v[15:0]}, 32'h8001);

      // R7: falling-edge sampling, no delay
      wr(4'd4, {8'd3, 1'b1, 3'd0, 20'h0});
      do_frame("R7", 1'b1, 5'h1C, 5'h12, 16'h0, 16'hC3A5, 3, 1'b1, 0, 1'b0, 1'b0);
      rd(4'd4, v);
      chk("R7", "falling-edge read literal", {16'd0, v[15:0]}, 32'hC3A5);

      // R7: rising edge with delay 2
      wr(4'd4, {8'd3, 1'b0, 3'd2, 20'h0});
      do_frame("R7", 1'b1, 5'h00, 5'h1F, 16'h0, 16'h5A0F, 3, 1'b0, 2, 1'b0, 1'b0);

      // R7: falling edge with delay 5 at half-period 2 (capture lands in next bit)
      wr(4'd4, {8'd2, 1'b1, 3'd5, 20'h0});
      do_frame("R7", 1'b1, 5'h15, 5'h0B, 16'h0, 16'h1234, 2, 1'b1, 5, 1'b0, 1'b0);

      // R3: threshold zero behaves as one
      wr(4'd4, {8'd0, 1'b0, 3'd0, 20'h0});
      do_frame("R3", 1'b0, 5'h01, 5'h02, 16'hFFFF, 16'h0, 1, 1'b0, 0, 1'b1, 1'b0);

      // R8: Clause 45 type and invalid opcodes are ignored
      m_rd = 1'b0;
      wr(4'd0, {1'b1, 2'b00, 1'b0, 2'b10, 5'h02, 5'h03, 16'h0});
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         rd(4'd4, v);
         if (!v[16] || mdc) bad++;
      end
      chk("R8", "activity after type-45 command", bad, 0);
      wr(4'd0, {1'b1, 2'b00, 1'b1, 2'b11, 5'h02, 5'h03, 16'h0});
      repeat (20) begin
         @(negedge clk);
         rd(4'd4, v);
         if (!v[16] || mdc) bad++;
      end
      chk("R8", "activity after opcode 11", bad, 0);
      rd(4'd0, v);
      chk("R8", "command readback unchanged", v, {1'b0, 2'b00, 1'b1, 2'b01, 5'h01, 5'h02, 16'hFFFF});

      // R9: writes while busy leave frame and registers alone
      wr(4'd4, {8'd2, 1'b0, 3'd0, 20'h0});
      do_frame("R9", 1'b0, 5'h0E, 5'h07, 16'h3C96, 16'h0, 2, 1'b0, 0, 1'b0, 1'b1);

      finish_run();
   end

endmodule